// File: doc/BRIEF.md
# Erase Sector Sequencer

The block sits between a software-facing erase request and a flash erase engine. A request gives a start byte address and a byte length. The block checks the request against the device size and against a table of up to `NREG` erase regions. Each region is described by its first address, the base-two logarithm of its sector size and the number of sectors it holds. If the request is accepted, the block breaks it into single-sector erase commands. It hands these to the engine one at a time and waits for the engine's response to each before it issues the next.

Sector sizes are not uniform across the device. A small-sector boot area may sit at either end of the array. For this reason each end of a request is checked against the sector size of the region that end falls in. The walk steps by the sector size of the region it is currently in, and it moves to the next region when the address reaches the end of that region. Every request ends with a one-cycle completion pulse that carries a two-bit status.

Top module: `erase_sector_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid` and `done_valid` are 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the cycle after `done_valid`.
- R2: A request whose start is greater than `dev_size`, or whose start plus length is greater than `dev_size`, completes with status 1 (range error) and issues no command.
- R3: The region for an address is the highest-numbered region whose offset is less than or equal to that address, or region 0 if there is none. An end address that lies exactly on a region's offset belongs to that region.
- R4: An in-range request of non-zero length whose start is not a multiple of its region's sector size completes with status 2 (alignment error) and issues no command.
- R5: An in-range request of non-zero length whose end (start plus length) is not a multiple of the sector size of the end's region completes with status 2 and issues no command.
- R6: An in-range request of zero length completes with status 0 and issues no command. The alignment checks do not apply to it.
- R7: An accepted request issues one command per sector, in increasing address order. Each command carries the sector address and the log2 of the current region's sector size, and the next address is the previous one plus that size.
- R8: When the walk address becomes equal to the current region's offset plus its sector count times its sector size, the walk uses the next region, unless the current region is the last one.
- R9: `cmd_valid`, `cmd_addr` and `cmd_lg` hold steady until `cmd_ready`. After a command is taken, no new command is presented until a response (`rsp_valid`) has been received.
- R10: A response with `rsp_err` = 1 ends the walk. No further command is issued, and the request completes with status 3 (engine error).
- R11: `done_valid` is high for exactly one cycle. For a request that issues no command, `done_valid` is high two clock edges after the accepting edge. Otherwise it is high one edge after the edge that takes the final (or failing) response.
- R12: The range check takes precedence over the alignment checks. The alignment checks take precedence over the zero-length rule only when the length is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_size | input | AW+1 | Device size in bytes |
| tbl_ofs | input | NREG*AW | Region start offsets, region i in bits [i*AW +: AW] |
| tbl_lg | input | NREG*SZW | Region log2 sector sizes, region i in bits [i*SZW +: SZW] |
| tbl_cnt | input | NREG*CW | Region sector counts, region i in bits [i*CW +: CW] |
| req_valid | input | 1 | Erase request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_start | input | AW | Request start byte address |
| req_len | input | AW+1 | Request length in bytes |
| cmd_valid | output | 1 | Sector erase command valid |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_addr | output | AW | Sector start address |
| cmd_lg | output | SZW | Log2 of the sector size in bytes |
| rsp_valid | input | 1 | Engine finished the last command |
| rsp_err | input | 1 | Engine reports failure with rsp_valid |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 range error, 2 alignment error, 3 engine error |

## Verification
A request that issues no command spends one cycle being judged, so its `done_valid` is sampled two edges after the accepting edge, and at the edge before that all three outputs are checked low. The first command is due in that same second cycle. Each later command, and the final completion pulse, is due one edge after the edge that takes a response. The bench drives `rsp_valid` exactly one cycle after every taken command and samples at the falling edge between these events. While `cmd_ready` is held low, the bench re-checks the presented command on every cycle, and one cycle after completion it confirms that `req_ready` has returned.

// File: rtl/erw_pkg.sv
package erw_pkg;

   typedef enum logic [1:0] {
      ST_OK     = 2'd0,
      ST_RANGE  = 2'd1,
      ST_ALIGN  = 2'd2,
      ST_ENGINE = 2'd3
   } erw_status_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_CHECK = 3'd1,
      PH_ISSUE = 3'd2,
      PH_WAIT  = 3'd3,
      PH_DONE  = 3'd4
   } erw_phase_e;

endpackage

// File: rtl/erw_region_find.sv
// Priority lookup: the last region whose offset does not exceed the address.
module erw_region_find #(
   parameter int NREG = 4,
   parameter int AW   = 24,
   parameter int SZW  = 5,
   parameter int IW   = 2
) (
   input  logic [AW:0]          addr,
   input  logic [NREG*AW-1:0]   tbl_ofs,
   input  logic [NREG*SZW-1:0]  tbl_lg,
   output logic [IW-1:0]        idx,
   output logic [SZW-1:0]       lg
);

   logic [NREG-1:0] at_or_past;

   for (genvar g = 0; g < NREG; g++) begin : g_cmp
      assign at_or_past[g] = ({1'b0, tbl_ofs[g*AW +: AW]} <= addr);
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NREG; i++) begin
         if (at_or_past[i]) idx = IW'(i);
      end
   end

   assign lg = tbl_lg[idx*SZW +: SZW];

endmodule

// File: rtl/erw_req_judge.sv
// Range and alignment verdict for a latched request.
module erw_req_judge
   import erw_pkg::*;
#(
   parameter int NREG = 4,
   parameter int AW   = 24,
   parameter int SZW  = 5,
   parameter int IW   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 checking,
   input  logic [AW:0]          dev_size,
   input  logic [NREG*AW-1:0]   tbl_ofs,
   input  logic [NREG*SZW-1:0]  tbl_lg,
   input  logic [AW-1:0]        start,
   input  logic [AW:0]          len,
   output erw_status_e          verdict,
   output logic                 zero_len,
   output logic [IW-1:0]        start_idx
);

   logic [AW+1:0]  end_w;
   logic           range_bad;
   logic           start_bad;
   logic           end_bad;
   logic [SZW-1:0] start_lg;
   logic [SZW-1:0] end_lg;
   logic [IW-1:0]  end_idx;
   logic [AW:0]    start_mask;
   logic [AW:0]    end_mask;

   assign end_w     = {2'b00, start} + {1'b0, len};
   assign range_bad = ({1'b0, start} > dev_size) || (end_w > {1'b0, dev_size});
   assign zero_len  = (len == '0);

   erw_region_find #(.NREG(NREG), .AW(AW), .SZW(SZW), .IW(IW)) u_find_start (
      .addr    ({1'b0, start}),
      .tbl_ofs (tbl_ofs),
      .tbl_lg  (tbl_lg),
      .idx     (start_idx),
      .lg      (start_lg)
   );

   erw_region_find #(.NREG(NREG), .AW(AW), .SZW(SZW), .IW(IW)) u_find_end (
      .addr    (end_w[AW:0]),
      .tbl_ofs (tbl_ofs),
      .tbl_lg  (tbl_lg),
      .idx     (end_idx),
      .lg      (end_lg)
   );

   assign start_mask = ~({(AW+1){1'b1}} << start_lg);
   assign end_mask   = ~({(AW+1){1'b1}} << end_lg);
   assign start_bad  = |({1'b0, start} & start_mask);
   assign end_bad    = |(end_w[AW:0] & end_mask);

   always_comb begin
      if (range_bad)                 verdict = ST_RANGE;
      else if (zero_len)             verdict = ST_OK;
      else if (start_bad || end_bad) verdict = ST_ALIGN;
      else                           verdict = ST_OK;
   end

   // With ascending offsets, the end of a valid request never lies in an earlier region.
   p_end_region_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (checking && verdict == ST_OK && !zero_len) |-> (end_idx >= start_idx));

   // A range failure is never masked by the alignment verdict.
   p_range_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (checking && (end_w > {1'b0, dev_size})) |-> (verdict == ST_RANGE));

endmodule

// File: rtl/erw_sector_walk.sv
// Request latch, sector iteration and engine handshake.
module erw_sector_walk
   import erw_pkg::*;
#(
   parameter int NREG = 4,
   parameter int AW   = 24,
   parameter int SZW  = 5,
   parameter int CW   = 8,
   parameter int IW   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NREG*AW-1:0]   tbl_ofs,
   input  logic [NREG*SZW-1:0]  tbl_lg,
   input  logic [NREG*CW-1:0]   tbl_cnt,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [AW-1:0]        req_start,
   input  logic [AW:0]          req_len,
   output logic [AW-1:0]        lat_start,
   output logic [AW:0]          lat_len,
   output logic                 checking,
   input  erw_status_e          verdict,
   input  logic                 zero_len,
   input  logic [IW-1:0]        start_idx,
   output logic                 cmd_valid,
   input  logic                 cmd_ready,
   output logic [AW-1:0]        cmd_addr,
   output logic [SZW-1:0]       cmd_lg,
   input  logic                 rsp_valid,
   input  logic                 rsp_err,
   output logic                 done_valid,
   output logic [1:0]           done_status
);

   erw_phase_e    phase;
   erw_status_e   status;
   logic [AW:0]   cur_addr;
   logic [AW:0]   remain;
   logic [IW-1:0] ridx;
   logic [IW-1:0] ridx_next;

   logic [SZW-1:0] cur_lg;
   logic [AW:0]    step;
   logic [AW:0]    rgn_end;
   logic [AW:0]    next_addr;
   logic [AW:0]    next_rem;
   logic           crossed;

   assign cur_lg    = tbl_lg[ridx*SZW +: SZW];
   assign step      = {{AW{1'b0}}, 1'b1} << cur_lg;
   assign rgn_end   = {1'b0, tbl_ofs[ridx*AW +: AW]}
                    + ({{(AW+1-CW){1'b0}}, tbl_cnt[ridx*CW +: CW]} << cur_lg);
   assign next_addr = cur_addr + step;
   assign next_rem  = (remain > step) ? (remain - step) : '0;
   assign crossed   = (next_addr == rgn_end);

   if (NREG == 1) begin : g_single_region
      assign ridx_next = ridx;
   end else begin : g_multi_region
      assign ridx_next = (crossed && ridx != IW'(NREG-1)) ? ridx + 1'b1 : ridx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         status    <= ST_OK;
         cur_addr  <= '0;
         remain    <= '0;
         ridx      <= '0;
         lat_start <= '0;
         lat_len   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (req_valid) begin
                  lat_start <= req_start;
                  lat_len   <= req_len;
                  phase     <= PH_CHECK;
               end
            end
            PH_CHECK: begin
               if (verdict != ST_OK || zero_len) begin
                  status <= verdict;
                  phase  <= PH_DONE;
               end else begin
                  cur_addr <= {1'b0, lat_start};
                  remain   <= lat_len;
                  ridx     <= start_idx;
                  phase    <= PH_ISSUE;
               end
            end
            PH_ISSUE: begin
               if (cmd_ready) phase <= PH_WAIT;
            end
            PH_WAIT: begin
               if (rsp_valid) begin
                  if (rsp_err) begin
                     status <= ST_ENGINE;
                     phase  <= PH_DONE;
                  end else begin
                     cur_addr <= next_addr;
                     remain   <= next_rem;
                     ridx     <= ridx_next;
                     if (next_rem == '0) begin
                        status <= ST_OK;
                        phase  <= PH_DONE;
                     end else begin
                        phase  <= PH_ISSUE;
                     end
                  end
               end
            end
            PH_DONE: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign req_ready   = (phase == PH_IDLE);
   assign checking    = (phase == PH_CHECK);
   assign cmd_valid   = (phase == PH_ISSUE);
   assign cmd_addr    = cur_addr[AW-1:0];
   assign cmd_lg      = cur_lg;
   assign done_valid  = (phase == PH_DONE);
   assign done_status = status;

   p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_lg)));

   p_no_cmd_before_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_valid);

   p_cmd_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ((cmd_addr & AW'(~({AW{1'b1}} << cmd_lg))) == '0));

   p_engine_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && rsp_valid && rsp_err) |=> (done_valid && done_status == 2'd3));

   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));

   p_ready_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/erase_sector_sequencer.sv
module erase_sector_sequencer
   import erw_pkg::*;
#(
   parameter int NREG = 4,
   parameter int AW   = 24,
   parameter int SZW  = 5,
   parameter int CW   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW:0]          dev_size,
   input  logic [NREG*AW-1:0]   tbl_ofs,
   input  logic [NREG*SZW-1:0]  tbl_lg,
   input  logic [NREG*CW-1:0]   tbl_cnt,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [AW-1:0]        req_start,
   input  logic [AW:0]          req_len,
   output logic                 cmd_valid,
   input  logic                 cmd_ready,
   output logic [AW-1:0]        cmd_addr,
   output logic [SZW-1:0]       cmd_lg,
   input  logic                 rsp_valid,
   input  logic                 rsp_err,
   output logic                 done_valid,
   output logic [1:0]           done_status
);

   localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

   if (NREG < 1)    begin : g_bad_nreg $error("NREG must be at least 1"); end
   if (AW < 2)      begin : g_bad_aw   $error("AW must be at least 2"); end
   if (CW > AW)     begin : g_bad_cw   $error("CW must not exceed AW"); end
   if (SZW < 1)     begin : g_bad_szw  $error("SZW must be at least 1"); end

   logic [AW-1:0] lat_start;
   logic [AW:0]   lat_len;
   logic          checking;
   erw_status_e   verdict;
   logic          zero_len;
   logic [IW-1:0] start_idx;

   erw_req_judge #(.NREG(NREG), .AW(AW), .SZW(SZW), .IW(IW)) u_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .checking  (checking),
      .dev_size  (dev_size),
      .tbl_ofs   (tbl_ofs),
      .tbl_lg    (tbl_lg),
      .start     (lat_start),
      .len       (lat_len),
      .verdict   (verdict),
      .zero_len  (zero_len),
      .start_idx (start_idx)
   );

   erw_sector_walk #(.NREG(NREG), .AW(AW), .SZW(SZW), .CW(CW), .IW(IW)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .tbl_ofs     (tbl_ofs),
      .tbl_lg      (tbl_lg),
      .tbl_cnt     (tbl_cnt),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_start   (req_start),
      .req_len     (req_len),
      .lat_start   (lat_start),
      .lat_len     (lat_len),
      .checking    (checking),
      .verdict     (verdict),
      .zero_len    (zero_len),
      .start_idx   (start_idx),
      .cmd_valid   (cmd_valid),
      .cmd_ready   (cmd_ready),
      .cmd_addr    (cmd_addr),
      .cmd_lg      (cmd_lg),
      .rsp_valid   (rsp_valid),
      .rsp_err     (rsp_err),
      .done_valid  (done_valid),
      .done_status (done_status)
   );

endmodule

// File: tb/erase_sector_sequencer_tb.sv
`timescale 1ns/1ps
module erase_sector_sequencer_tb;

   localparam int NREG = 4;
   localparam int AW   = 24;
   localparam int SZW  = 5;
   localparam int CW   = 8;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [AW:0]         dev_size = '0;
   logic [NREG*AW-1:0]  tbl_ofs = '0;
   logic [NREG*SZW-1:0] tbl_lg = '0;
   logic [NREG*CW-1:0]  tbl_cnt = '0;
   logic                req_valid = 1'b0;
   logic                req_ready;
   logic [AW-1:0]       req_start = '0;
   logic [AW:0]         req_len = '0;
   logic                cmd_valid;
   logic                cmd_ready = 1'b0;
   logic [AW-1:0]       cmd_addr;
   logic [SZW-1:0]      cmd_lg;
   logic                rsp_valid = 1'b0;
   logic                rsp_err = 1'b0;
   logic                done_valid;
   logic [1:0]          done_status;

   always #10 clk = ~clk;

   erase_sector_sequencer #(.NREG(NREG), .AW(AW), .SZW(SZW), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .dev_size(dev_size), .tbl_ofs(tbl_ofs),
      .tbl_lg(tbl_lg), .tbl_cnt(tbl_cnt), .req_valid(req_valid),
      .req_ready(req_ready), .req_start(req_start), .req_len(req_len),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_lg(cmd_lg), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .done_valid(done_valid), .done_status(done_status)
   );

   int     n_checks = 0;
   int     n_errors = 0;
   bit     finished = 1'b0;

   longint m_ofs [NREG];
   int     m_lg  [NREG];
   longint m_cnt [NREG];
   longint m_size;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic load_table(input longint ofs [NREG], input int lg [NREG],
                             input longint cnt [NREG], input longint size);
      for (int i = 0; i < NREG; i++) begin
         m_ofs[i] = ofs[i]; m_lg[i] = lg[i]; m_cnt[i] = cnt[i];
         tbl_ofs[i*AW +: AW]   = AW'(ofs[i]);
         tbl_lg[i*SZW +: SZW]  = SZW'(lg[i]);
         tbl_cnt[i*CW +: CW]   = CW'(cnt[i]);
      end
      m_size   = size;
      dev_size = (AW+1)'(size);
   endtask

   function automatic int find_rgn(input longint a);
      int r = 0;
      for (int i = 0; i < NREG; i++) if (m_ofs[i] <= a) r = i;
      return r;
   endfunction

   // Reference model, then drive the request and follow the outputs cycle by cycle.
   task automatic do_req(input string tag, input longint start, input longint len,
                         input int err_at, input int hold);
      longint q_addr [$];
      int     q_lg   [$];
      int     exp_st;
      int     n_issue;
      longint e = start + len;
      int     rs = find_rgn(start);
      int     re = find_rgn(e);
      if (start > m_size || e > m_size)                 exp_st = 1;
      else if (len == 0)                                exp_st = 0;
      else if ((start % (64'd1 << m_lg[rs])) != 0 ||
               (e % (64'd1 << m_lg[re])) != 0)          exp_st = 2;
      else                                              exp_st = 0;
      if (exp_st == 0 && len != 0) begin
         longint a = start;
         longint rem = len;
         int     r = rs;
         while (rem > 0) begin
            longint sz = 64'd1 << m_lg[r];
            q_addr.push_back(a);
            q_lg.push_back(m_lg[r]);
            a += sz;
            rem = (rem > sz) ? rem - sz : 0;
            if (a == m_ofs[r] + (m_cnt[r] << m_lg[r]) && r < NREG-1) r++;
         end
      end
      n_issue = q_addr.size();
      if (err_at >= 0 && err_at < n_issue) begin
         n_issue = err_at + 1;
         exp_st  = 3;
      end

      @(negedge clk);
      chk(req_ready == 1'b1, tag, "req_ready before request (R1)", req_ready, 1);
      req_valid = 1'b1;
      req_start = AW'(start);
      req_len   = (AW+1)'(len);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready && !cmd_valid && !done_valid, tag, "outputs in judging cycle (R11)",
          {req_ready, cmd_valid, done_valid}, 0);
      @(negedge clk);
      for (int k = 0; k < n_issue; k++) begin
         chk(cmd_valid == 1'b1, tag, "cmd_valid (R7)", cmd_valid, 1);
         chk(cmd_addr == AW'(q_addr[k]), tag, "cmd_addr (R7/R8)", cmd_addr, q_addr[k]);
         chk(cmd_lg == SZW'(q_lg[k]), tag, "cmd_lg (R7/R8)", cmd_lg, q_lg[k]);
         for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_addr == AW'(q_addr[k]) && cmd_lg == SZW'(q_lg[k]),
                tag, "held command (R9)", cmd_addr, q_addr[k]);
         end
         cmd_ready = 1'b1;
         @(negedge clk);
         cmd_ready = 1'b0;
         chk(!cmd_valid && !done_valid, tag, "quiet while waiting for response (R9)",
             {cmd_valid, done_valid}, 0);
         rsp_valid = 1'b1;
         rsp_err   = (k == err_at);
         @(negedge clk);
         rsp_valid = 1'b0;
         rsp_err   = 1'b0;
      end
      chk(done_valid == 1'b1, tag, "done_valid due (R11)", done_valid, 1);
      chk(done_status == 2'(exp_st), tag, "done_status", done_status, exp_st);
      chk(cmd_valid == 1'b0, tag, "no command at completion (R10)", cmd_valid, 0);
      @(negedge clk);
      chk(!done_valid && req_ready, tag, "done single cycle, ready back (R11)",
          {done_valid, req_ready}, 1);
   endtask

   initial begin
      longint b_ofs [NREG] = '{64'h0, 64'h4000, 64'h8000, 64'h10000};
      int     b_lg  [NREG] = '{14, 13, 15, 16};
      longint b_cnt [NREG] = '{1, 2, 1, 31};
      longint t_ofs [NREG] = '{64'h0, 64'h1F0000, 64'h1F8000, 64'h1FC000};
      int     t_lg  [NREG] = '{16, 15, 13, 14};
      longint t_cnt [NREG] = '{31, 1, 2, 1};

      load_table(b_ofs, b_lg, b_cnt, 64'h200000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !cmd_valid && !done_valid, "R1", "reset state",
          {req_ready, cmd_valid, done_valid}, 3'b100);

      // Bottom-boot table
      do_req("R2",  64'h200001, 0,          -1, 0);
      do_req("R2",  64'h1F0000, 64'h20000,  -1, 0);
      do_req("R12", 64'h2000,   64'h300000, -1, 0);
      do_req("R4",  64'h2000,   64'h2000,   -1, 0);
      do_req("R5",  64'h0,      64'h5000,   -1, 0);
      do_req("R5",  64'h10000,  64'h8000,   -1, 0);
      do_req("R6",  64'h2000,   0,          -1, 0);
      do_req("R6",  64'h200000, 0,          -1, 0);
      do_req("R7",  64'h0,      64'h20000,  -1, 0);
      do_req("R8",  64'h6000,   64'h2A000,  -1, 1);
      do_req("R9",  64'h100000, 64'h20000,  -1, 3);
      do_req("R10", 64'h0,      64'h20000,   2, 0);
      do_req("R10", 64'h10000,  64'h10000,   0, 0);
      do_req("R7",  64'h0,      64'h200000, -1, 0);

      // Top-boot table
      load_table(t_ofs, t_lg, t_cnt, 64'h200000);
      do_req("R8",  64'h1E0000, 64'h20000,  -1, 0);
      do_req("R4",  64'h1F9000, 64'h1000,   -1, 0);
      do_req("R3",  64'h1F8000, 64'h4000,   -1, 0);
      do_req("R3",  64'h1F0000, 64'hA000,   -1, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule